// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from up to 64 sources and picks one of them to be serviced. Each source has a pending flag, an enable bit, a five-bit priority made of a major and a minor part, and a 32-bit vector offset. Every cycle the controller looks at all pending, enabled sources and registers the best one. It then drives an interrupt request, the winner's number and the winner's vector offset.

Software reaches every register through a simple word-addressed bus: address, write data, write strobe, and read data that is combinational on the address. Flag, enable, priority and control words each have a set alias and a clear alias, so single bits change without a read-modify-write. Sources come in three kinds. Persistent sources keep their flag set for as long as the peripheral holds its request. Edge sources latch a rising request until software clears it. The lowest sources are wired to external pins, and each pin has its own edge polarity.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low, and `vec_num_o` and `vec_off_o` are zero.
- R2: Source n has its flag in the word at byte address 0x040 + 0x10*(n/32), bit n%32, and its enable bit at 0x0C0 + 0x10*(n/32), bit n%32. Writing the base address stores the data. Writing base+0x8 sets the bits that are 1 in the data. Writing base+0x4 clears the bits that are 1 in the data. Reading any of these addresses returns the word.
- R3: Source n has its priority at byte address 0x140 + 0x10*(n/4), in bits (n%4)*8+4 down to (n%4)*8. Bits 4:2 of the field are the major priority and bits 1:0 are the minor priority. Bits 7:5 of each byte lane read as zero. The set and clear aliases of R2 apply here too.
- R4: A source takes part in selection only if its flag is 1, its enable is 1 and its major priority is not zero. The winner has the largest five-bit priority value, which means major first and then minor. Among equal values, the lowest source number wins.
- R5: `irq_o` is high exactly when a winner exists. `vec_num_o` and status bits 7:0 (byte address 0x020) give the winner's number, or 0 when there is no winner, and status bits 31:8 read zero. These outputs follow the flag, enable and priority state with one clock cycle of delay.
- R6: Source n has a 32-bit vector offset register at byte address 0x540 + 4*n that is written and read as a plain word. `vec_off_o` shows the offset register of the source reported on `vec_num_o`.
- R7: A persistent source (bit n of PERSIST_MASK set, default sources 32-63) sets its flag on the clock edge after its request is seen high. A clear of that flag has no effect while the request stays high. After the request drops, the flag stays set until software clears it.
- R8: A non-persistent internal source (default sources 8-31) sets its flag on the clock edge after its request rises. The flag stays set after the request falls. A clear removes the flag, and a request that is still held high does not set it again until a new rising edge.
- R9: Source p below N_EXT follows pin `ext_pin[p]`. With control bit p = 1 a rising pin edge sets the flag, and with control bit p = 0 a falling pin edge sets it. The opposite edge has no effect. The flag becomes set on the third clock edge after the pin changes.
- R10: The control word at byte address 0x000 holds the N_EXT polarity bits, with the same write, set (+0x8) and clear (+0x4) aliases. Bits at N_EXT and above read as zero.
- R11: Writes to the status address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_req | input | N_SRC-N_EXT | Requests of internal sources N_EXT and up |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| irq_o | output | 1 | A winner exists |
| vec_num_o | output | 8 | Number of the winning source |
| vec_off_o | output | 32 | Vector offset of the winning source |

## Verification
Each result has a fixed latency. A register write shows on `bus_rdata` right after the clock edge that takes it. An internal request sets its flag on the next edge. A pin change sets its flag on the third edge. The arbitration outputs lag the state that drives them by one further edge. The bench drives inputs on falling edges and samples exactly at these points. At the external pins and the persistent source it also samples one edge early, where the old value must still be present, so a latency that is one cycle too short or too long is caught. The arbitration sweep computes the expected winner from the programmed flags, enables and priorities and checks it against the outputs one edge after the last write.

// File: rtl/vpic_pkg.sv
// Shared constants and helpers for the vectored priority interrupt controller.
// Assumes byte addresses, 32-bit words and a 12-bit register space.
package vpic_pkg;

    localparam logic [11:0] CTRL_BASE = 12'h000;
    localparam logic [11:0] STAT_BASE = 12'h020;
    localparam logic [11:0] FLAG_BASE = 12'h040;
    localparam logic [11:0] EN_BASE   = 12'h0C0;
    localparam logic [11:0] PRIO_BASE = 12'h140;
    localparam logic [11:0] VOFF_BASE = 12'h540;
    localparam int          WORD_STEP = 16;

    typedef enum logic [1:0] {OP_WR, OP_CLR, OP_SET, OP_NONE} bus_op_e;

    // Map the low address nibble to the access flavour of a 16-byte register slot.
    function automatic bus_op_e op_of(input logic [3:0] lo);
        case (lo)
            4'h0:    return OP_WR;
            4'h4:    return OP_CLR;
            4'h8:    return OP_SET;
            default: return OP_NONE;
        endcase
    endfunction

    // New register value after a plain, set or clear write.
    function automatic logic [31:0] apply_op(input bus_op_e op, input logic [31:0] cur,
                                             input logic [31:0] wd);
        case (op)
            OP_WR:   return wd;
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/vpic_edge_sync.sv
// External pin front end: a two-flop synchronizer, then one-cycle pulses on the edge
// that the polarity bit selects (1 = rising, 0 = falling). Assumes pins are asynchronous.
module vpic_edge_sync #(
    parameter int N_EXT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] pol,
    output logic [N_EXT-1:0] evt
);
    logic [N_EXT-1:0] sync1_q, sync2_q, last_q;

    // Synchronize the pins and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            last_q  <= '0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            last_q  <= sync2_q;
        end
    end

    // A change whose new level matches the polarity bit is the selected edge (R9).
    always_comb evt = (sync2_q ^ last_q) & ~(sync2_q ^ pol);

    for (genvar p = 0; p < N_EXT; p++) begin : g_chk
        // R9: a level change yields a single-cycle event
        a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            evt[p] |=> !evt[p]);
    end
endmodule

// File: rtl/vpic_flag_bank.sv
// Pending flags for all sources. Sources below N_EXT take pin events, the rest take
// internal requests that are level (persistent) or rising-edge captured, per PERSIST_MASK.
// Hardware setting wins over a software clear in the same cycle.
module vpic_flag_bank #(
    parameter int               N_SRC        = 64,
    parameter int               N_EXT        = 8,
    parameter logic [N_SRC-1:0] PERSIST_MASK = '0,
    localparam int              N_INT        = N_SRC - N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_evt,
    input  logic [N_INT-1:0] src_req,
    input  logic [N_SRC-1:0] sw_set,
    input  logic [N_SRC-1:0] sw_clr,
    output logic [N_SRC-1:0] flag_q
);
    logic [N_SRC-1:0] hw_set;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i < N_EXT) begin : g_ext
            assign hw_set[i] = ext_evt[i];
        end else if (PERSIST_MASK[i]) begin : g_lvl
            assign hw_set[i] = src_req[i-N_EXT];
            // R7: a held request keeps the flag set whatever software writes
            a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
                src_req[i-N_EXT] |=> flag_q[i]);
        end else begin : g_edge
            logic prev_q;
            // Remember the request level to spot its rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src_req[i-N_EXT];
            end
            assign hw_set[i] = src_req[i-N_EXT] & ~prev_q;
            // R8: a rising request latches the flag
            a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (src_req[i-N_EXT] && !prev_q) |=> flag_q[i]);
        end
    end

    // Merge software writes and hardware setting into the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ((flag_q & ~sw_clr) | sw_set) | hw_set;
    end

    // R8: a flag only goes away through a software clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~sw_clr) != '0) |=> (($past(flag_q & ~sw_clr) & ~flag_q) == '0));
endmodule

// File: rtl/vpic_arbiter.sv
// Combinational winner search: eligible means flag, enable and a non-zero major priority.
// The largest five-bit priority wins, and the lowest source number wins among equals.
module vpic_arbiter #(
    parameter  int N_SRC = 64,
    localparam int ID_W  = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      flag,
    input  logic [N_SRC-1:0]      en,
    input  logic [N_SRC-1:0][4:0] prio,
    output logic                  valid,
    output logic [ID_W-1:0]       id
);
    logic [N_SRC-1:0] elig;
    logic [4:0]       best_p;

    // Mark the sources allowed to compete (R4).
    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            elig[i] = flag[i] & en[i] & (prio[i][4:2] != 3'd0);
    end

    // Ascending scan and strict compare, so the lowest index wins a tie.
    always_comb begin
        valid  = 1'b0;
        id     = '0;
        best_p = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!valid || prio[i] > best_p)) begin
                valid  = 1'b1;
                id     = ID_W'(i);
                best_p = prio[i];
            end
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        // R4: no eligible source outranks the winner
        a_r4_no_better: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && elig[i]) |-> (prio[i] <= best_p));
        // R4: equal priority resolves to the lowest number
        a_r4_low_index: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && elig[i] && prio[i] == best_p) |-> (id <= ID_W'(i)));
    end
    // R4: no winner means nobody is eligible
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (elig == '0));
endmodule

// File: rtl/vpic_ctrl.sv
// Top of the vectored priority interrupt controller: register decode with set/clear
// aliases, configuration storage, a registered winner and the vector outputs.
// Assumes N_SRC is a multiple of 32 (at most 256) and N_EXT is at most 8.
module vpic_ctrl
    import vpic_pkg::*;
#(
    parameter  int               N_SRC        = 64,
    parameter  int               N_EXT        = 8,
    parameter  int               ADDR_W       = 12,
    parameter  logic [N_SRC-1:0] PERSIST_MASK = 64'hFFFF_FFFF_0000_0000,
    localparam int               N_INT        = N_SRC - N_EXT,
    localparam int               N_WORD       = N_SRC / 32,
    localparam int               N_PWORD      = N_SRC / 4,
    localparam int               ID_W         = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [N_INT-1:0]  src_req,
    input  logic [N_EXT-1:0]  ext_pin,
    output logic              irq_o,
    output logic [7:0]        vec_num_o,
    output logic [31:0]       vec_off_o
);
    logic [31:0]             a, fw, ew, pw, vi;
    bus_op_e                 op;
    logic                    hit_ctrl, hit_stat, hit_flag, hit_en, hit_prio, hit_voff;
    logic [N_EXT-1:0]        pol_q, ext_evt;
    logic [N_SRC-1:0]        en_q, flag_q, sw_set, sw_clr;
    logic [N_SRC-1:0][4:0]   prio_q;
    logic [N_SRC-1:0][31:0]  voff_q;
    logic [N_PWORD-1:0][31:0] prio_word;
    logic                    arb_valid, irq_q;
    logic [ID_W-1:0]         arb_id, win_id_q;

    // Decode the address into a region, a word index and an access flavour.
    always_comb begin
        a        = 32'(bus_addr);
        op       = op_of(a[3:0]);
        hit_ctrl = (a < 32'(WORD_STEP));
        hit_stat = (a[31:4] == 28'(STAT_BASE >> 4));
        hit_flag = (a >= 32'(FLAG_BASE)) && (a < 32'(FLAG_BASE) + 32'(WORD_STEP * N_WORD));
        hit_en   = (a >= 32'(EN_BASE))   && (a < 32'(EN_BASE)   + 32'(WORD_STEP * N_WORD));
        hit_prio = (a >= 32'(PRIO_BASE)) && (a < 32'(PRIO_BASE) + 32'(WORD_STEP * N_PWORD));
        hit_voff = (a >= 32'(VOFF_BASE)) && (a < 32'(VOFF_BASE) + 32'(4 * N_SRC))
                   && (a[1:0] == 2'b00);
        fw = (a - 32'(FLAG_BASE)) >> 4;
        ew = (a - 32'(EN_BASE)) >> 4;
        pw = (a - 32'(PRIO_BASE)) >> 4;
        vi = (a - 32'(VOFF_BASE)) >> 2;
    end

    // Turn flag-word writes into per-bit set and clear requests (R2).
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        for (int w = 0; w < N_WORD; w++) begin
            if (bus_we && hit_flag && fw == 32'(w)) begin
                case (op)
                    OP_WR:   begin
                        sw_set[32*w +: 32] = bus_wdata;
                        sw_clr[32*w +: 32] = ~bus_wdata;
                    end
                    OP_SET:  sw_set[32*w +: 32] = bus_wdata;
                    OP_CLR:  sw_clr[32*w +: 32] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Pack four priority fields per word, one per byte lane (R3).
    always_comb begin
        for (int j = 0; j < N_PWORD; j++) begin
            prio_word[j] = '0;
            for (int k = 0; k < 4; k++)
                prio_word[j][8*k +: 5] = prio_q[4*j + k];
        end
    end

    // Polarity bits of the external pins (R10).
    always_ff @(posedge clk) begin
        if (!rst_n)                       pol_q <= '0;
        else if (bus_we && hit_ctrl)      pol_q <= N_EXT'(apply_op(op, 32'(pol_q), bus_wdata));
    end

    // Enable words with write, set and clear aliases (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int w = 0; w < N_WORD; w++)
                if (bus_we && hit_en && ew == 32'(w))
                    en_q[32*w +: 32] <= apply_op(op, en_q[32*w +: 32], bus_wdata);
        end
    end

    // Priority fields, updated lane by lane since every alias acts bitwise (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else begin
            for (int j = 0; j < N_PWORD; j++)
                if (bus_we && hit_prio && pw == 32'(j))
                    for (int k = 0; k < 4; k++)
                        prio_q[4*j + k] <= 5'(apply_op(op, 32'(prio_q[4*j + k]),
                                                       32'(bus_wdata[8*k +: 5])));
        end
    end

    // Per-source vector offsets, plain word writes (R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            voff_q <= '0;
        end else begin
            for (int n = 0; n < N_SRC; n++)
                if (bus_we && hit_voff && vi == 32'(n))
                    voff_q[n] <= bus_wdata;
        end
    end

    vpic_edge_sync #(.N_EXT(N_EXT)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .pin (ext_pin),
        .pol (pol_q),
        .evt (ext_evt)
    );

    vpic_flag_bank #(.N_SRC(N_SRC), .N_EXT(N_EXT), .PERSIST_MASK(PERSIST_MASK)) u_flags (
        .clk (clk),
        .rst_n (rst_n),
        .ext_evt (ext_evt),
        .src_req (src_req),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .flag_q (flag_q)
    );

    vpic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk (clk),
        .rst_n (rst_n),
        .flag (flag_q),
        .en (en_q),
        .prio (prio_q),
        .valid (arb_valid),
        .id (arb_id)
    );

    // Register the winner; the number is forced to zero when nobody wins (R5).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q    <= 1'b0;
            win_id_q <= '0;
        end else begin
            irq_q    <= arb_valid;
            win_id_q <= arb_valid ? arb_id : '0;
        end
    end

    assign irq_o     = irq_q;
    assign vec_num_o = 8'(win_id_q);

    // Look up the offset register of the reported source (R6).
    always_comb begin
        vec_off_o = '0;
        for (int n = 0; n < N_SRC; n++)
            if (win_id_q == ID_W'(n)) vec_off_o = voff_q[n];
    end

    // Read mux; the status address has no write path (R11).
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl && op != OP_NONE) bus_rdata = 32'(pol_q);
        if (hit_stat && op != OP_NONE) bus_rdata = 32'(vec_num_o);
        for (int w = 0; w < N_WORD; w++) begin
            if (hit_flag && op != OP_NONE && fw == 32'(w)) bus_rdata = flag_q[32*w +: 32];
            if (hit_en && op != OP_NONE && ew == 32'(w))   bus_rdata = en_q[32*w +: 32];
        end
        for (int j = 0; j < N_PWORD; j++)
            if (hit_prio && op != OP_NONE && pw == 32'(j)) bus_rdata = prio_word[j];
        for (int n = 0; n < N_SRC; n++)
            if (hit_voff && vi == 32'(n)) bus_rdata = voff_q[n];
    end

    // R5: without a request the reported number is zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_num_o == 8'd0));
    // R10: polarity state only changes through a control-word write
    a_r10_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && hit_ctrl) |=> $stable(pol_q));
endmodule

// File: tb/vpic_ctrl_bench.sv
// Self-checking bench for vpic_ctrl with default parameters: register sweeps,
// an arbitration sweep against a computed winner, and timed source-kind scenarios.
module vpic_ctrl_bench;
    localparam int N = 64;
    localparam int NX = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [N-NX-1:0] src_req = '0;
    logic [NX-1:0]   ext_pin = '0;
    logic        irq_o;
    logic [7:0]  vec_num_o;
    logic [31:0] vec_off_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_flag, m_en;
    logic [4:0]  m_pr [N];
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    vpic_ctrl u_vpic_ctrl (
        .clk (clk),
        .rst_n (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we (bus_we),
        .bus_rdata (bus_rdata),
        .src_req (src_req),
        .ext_pin (ext_pin),
        .irq_o (irq_o),
        .vec_num_o (vec_num_o),
        .vec_off_o (vec_off_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [11:0] ad, input logic [31:0] d);
        bus_addr = ad; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] ad, output logic [31:0] d);
        bus_addr = ad;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] off_val(input int n);
        return 32'hC000_0000 ^ (32'(n) * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] pword(input int j);
        return {3'b0, m_pr[4*j+3], 3'b0, m_pr[4*j+2], 3'b0, m_pr[4*j+1], 3'b0, m_pr[4*j]};
    endfunction

    initial begin
        logic [31:0] v;
        logic        ev;
        int          eid;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(12'h000, v); chk("R1 ctrl", v, 0);
        rd(12'h020, v); chk("R1 status", v, 0);
        for (int w = 0; w < 2; w++) begin
            rd(12'(12'h040 + 16*w), v); chk("R1 flag", v, 0);
            rd(12'(12'h0C0 + 16*w), v); chk("R1 enable", v, 0);
        end
        rd(12'h140, v); chk("R1 prio first", v, 0);
        rd(12'h230, v); chk("R1 prio last", v, 0);
        rd(12'h63C, v); chk("R1 offset last", v, 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 vec_num", 32'(vec_num_o), 0);
        chk("R1 vec_off", vec_off_o, 0);

        // R2: flag bit placement with set and clear aliases, every source
        for (int n = 0; n < N; n++) begin
            logic [11:0] fb = 12'(12'h040 + 16*(n/32));
            wr(fb + 12'h8, 32'(1) << (n % 32));
            rd(fb, v); chk("R2 flag set alias", v, 32'(1) << (n % 32));
            wr(fb + 12'h4, 32'(1) << (n % 32));
            rd(fb, v); chk("R2 flag clear alias", v, 0);
        end
        // R2: enable words, plain then alias writes
        for (int w = 0; w < 2; w++) begin
            logic [11:0] eb = 12'(12'h0C0 + 16*w);
            wr(eb, 32'hA5A5_0F0F);      rd(eb, v); chk("R2 enable write", v, 32'hA5A5_0F0F);
            wr(eb + 12'h8, 32'h0000_F0F0); rd(eb + 12'h8, v); chk("R2 enable set", v, 32'hA5A5_FFFF);
            wr(eb + 12'h4, 32'hFFFF_0000); rd(eb + 12'h4, v); chk("R2 enable clear", v, 32'h0000_FFFF);
            wr(eb, 0);                  rd(eb, v); chk("R2 enable zero", v, 0);
        end

        // R3: byte-lane packing and unused lane bits
        for (int j = 0; j < N/4; j++) begin
            logic [11:0] pb = 12'(12'h140 + 16*j);
            wr(pb, 32'hFFFF_FFFF); rd(pb, v); chk("R3 lanes full", v, 32'h1F1F_1F1F);
            wr(pb + 12'h4, 32'h0000_00FF); rd(pb, v); chk("R3 lane clear", v, 32'h1F1F_1F00);
            for (int k = 0; k < 4; k++) m_pr[4*j+k] = 5'(4*j + k + 1);
            wr(pb, pword(j)); rd(pb, v); chk("R3 lane pattern", v, pword(j));
        end

        // R10: control word
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, v); chk("R10 ctrl width", v, 32'h0000_00FF);
        wr(12'h004, 32'h0000_000F); rd(12'h000, v); chk("R10 ctrl clear", v, 32'h0000_00F0);
        wr(12'h008, 32'h0000_0101); rd(12'h000, v); chk("R10 ctrl set", v, 32'h0000_00F1);
        wr(12'h000, 32'h0);         rd(12'h000, v); chk("R10 ctrl zero", v, 0);

        // R6: offset registers
        for (int n = 0; n < N; n++) wr(12'(12'h540 + 4*n), off_val(n));
        for (int n = 0; n < N; n++) begin
            rd(12'(12'h540 + 4*n), v); chk("R6 offset readback", v, off_val(n));
        end

        // R4, R5, R6: arbitration sweep
        for (int t = 0; t < 200; t++) begin
            if (t == 0) begin
                m_flag = '1; m_en = '1;
                for (int n = 0; n < N; n++) m_pr[n] = 5'h1F;
            end else if (t == 1) begin
                for (int n = 0; n < N; n++) m_pr[n] = 5'h03;
            end else if (t == 2) begin
                m_en = 64'h8000_0000_0000_0000;
                m_pr[63] = 5'h04;
            end else begin
                rng = nxt(rng); m_flag[31:0]  = rng;
                rng = nxt(rng); m_flag[63:32] = rng;
                rng = nxt(rng); m_en[31:0]    = rng;
                rng = nxt(rng); m_en[63:32]   = rng;
                for (int n = 0; n < N; n++) begin
                    rng = nxt(rng);
                    m_pr[n] = (t % 4 == 0) ? {rng[0], 4'b0100} : rng[4:0];
                end
            end
            wr(12'h040, m_flag[31:0]); wr(12'h050, m_flag[63:32]);
            wr(12'h0C0, m_en[31:0]);   wr(12'h0D0, m_en[63:32]);
            for (int j = 0; j < N/4; j++) wr(12'(12'h140 + 16*j), pword(j));
            ev = 1'b0; eid = 0;
            for (int n = 0; n < N; n++) begin
                if (m_flag[n] && m_en[n] && m_pr[n][4:2] != 3'd0 &&
                    (!ev || m_pr[n] > m_pr[eid])) begin
                    ev = 1'b1; eid = n;
                end
            end
            @(negedge clk);
            chk("R5 irq", 32'(irq_o), 32'(ev));
            chk("R4 winner", 32'(vec_num_o), 32'(eid));
            rd(12'h020, v); chk("R5 status", v, 32'(eid));
            chk("R6 vec_off", vec_off_o, off_val(eid));
        end

        // clear state before the source-kind scenarios
        wr(12'h040, 0); wr(12'h050, 0); wr(12'h0C0, 0); wr(12'h0D0, 0);
        @(negedge clk);
        chk("R5 irq cleared", 32'(irq_o), 0);

        // R7: persistent source 40 (word 1 bit 8, request bit 32)
        wr(12'h0D8, 32'h100);
        wr(12'h1E0, 32'h08);
        src_req[32] = 1'b1;
        rd(12'h050, v); chk("R7 not yet set", v, 0);
        @(negedge clk);
        rd(12'h050, v); chk("R7 set after one edge", v, 32'h100);
        chk("R5 irq one edge later", 32'(irq_o), 0);
        @(negedge clk);
        chk("R5 irq raised", 32'(irq_o), 1);
        chk("R5 vec_num 40", 32'(vec_num_o), 40);
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, v); chk("R11 status unchanged", v, 40);
        wr(12'h054, 32'h100);
        rd(12'h050, v); chk("R7 clear ignored while held", v, 32'h100);
        src_req[32] = 1'b0;
        repeat (2) @(negedge clk);
        rd(12'h050, v); chk("R7 stays after release", v, 32'h100);
        wr(12'h054, 32'h100);
        rd(12'h050, v); chk("R7 clear after release", v, 0);
        @(negedge clk);
        chk("R7 irq dropped", 32'(irq_o), 0);

        // R8: edge source 20 (word 0 bit 20, request bit 12)
        src_req[12] = 1'b1;
        rd(12'h040, v); chk("R8 not yet set", v, 0);
        @(negedge clk);
        rd(12'h040, v); chk("R8 set on rise", v, 32'h0010_0000);
        src_req[12] = 1'b0;
        repeat (2) @(negedge clk);
        rd(12'h040, v); chk("R8 sticky after fall", v, 32'h0010_0000);
        wr(12'h044, 32'h0010_0000);
        rd(12'h040, v); chk("R8 cleared", v, 0);
        src_req[12] = 1'b1;
        @(negedge clk);
        rd(12'h040, v); chk("R8 second rise", v, 32'h0010_0000);
        wr(12'h044, 32'h0010_0000);
        repeat (3) @(negedge clk);
        rd(12'h040, v); chk("R8 held level no reset", v, 0);
        src_req[12] = 1'b0;
        @(negedge clk);

        // R9: every external pin with both polarities
        for (int p = 0; p < NX; p++) begin
            wr(12'h000, 32'(1) << p);
            ext_pin[p] = 1'b1;
            repeat (2) @(negedge clk);
            rd(12'h040, v); chk("R9 rising too early", v & 32'hFF, 0);
            @(negedge clk);
            rd(12'h040, v); chk("R9 rising on third edge", v & 32'hFF, 32'(1) << p);
            wr(12'h044, 32'hFF);
            ext_pin[p] = 1'b0;
            repeat (4) @(negedge clk);
            rd(12'h040, v); chk("R9 falling ignored", v & 32'hFF, 0);
            wr(12'h004, 32'(1) << p);
            ext_pin[p] = 1'b1;
            repeat (4) @(negedge clk);
            rd(12'h040, v); chk("R9 rising ignored", v & 32'hFF, 0);
            ext_pin[p] = 1'b0;
            repeat (2) @(negedge clk);
            rd(12'h040, v); chk("R9 falling too early", v & 32'hFF, 0);
            @(negedge clk);
            rd(12'h040, v); chk("R9 falling on third edge", v & 32'hFF, 32'(1) << p);
            wr(12'h044, 32'hFF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule